// File: doc/BRIEF.md
# SPI Target with Select-Gated Shift Loading

This block is an 8-bit serial peripheral target for a register-mapped host. An external controller drives the serial clock, the select line and the data-in line. The block captures eight data-in bits into a receive buffer, most significant bit first. At the same time it sends a byte that software placed in its shift register out on the data-out pin. All three serial inputs pass through two-flop synchronisers, so the system clock must run at least four times faster than the serial clock.

Software picks the idle level of the serial clock and which edge samples data. The block decides when a software write may load the shift register. A write is taken while select is high at any time. While select is low, a write is taken only between bytes, and only when data is sampled on the second clock edge. After each byte a completion flag rises, and it can raise an interrupt. Software clears the flag with two accesses: first it reads the status register while the flag is set, then it reads or writes the data register. If another byte finishes before the flag is cleared, the block records an overrun and keeps the earlier byte.

Top module: `sspi_target`

## Requirements
- R1: After reset, all three registers read zero, `irq` is 0, `miso` is 0 and `miso_oe` is 0.
- R2: The block acts on serial traffic only when control bit 0 (enable) is 1 and control bit 1 (master) is 0. Otherwise clock edges set no flag and `miso_oe` stays 0.
- R3: With config bit 0 as the clock idle level and config bit 1 as the phase, data-in is sampled on the first clock edge after idle when phase is 0, and on the second when phase is 1. Eight samples, MSB first, form the byte read at address 2. The flag (status bit 7) is set at the eighth sample.
- R4: The byte in the shift register appears on `miso` MSB first. Each bit is valid at the edge where the controller samples it, in all four clock modes.
- R5: With phase 0, a data write while select is low is not loaded. The next byte then sends the previously received byte.
- R6: With phase 1, a data write while select stays low between bytes is loaded and sent in the next byte.
- R7: `irq` is high exactly when the flag is set, control bit 2 (interrupt enable) is 1 and `irq_mask` is 0.
- R8: The flag clears only after a status read made while it is set, followed by a read or write of the data register. A data access with no prior status read leaves the flag set.
- R9: A data write made while the flag is set and status has not been read is discarded. The shift register keeps its content.
- R10: If a byte completes while the flag is still set, status bit 6 (overrun) is set and the data register keeps the earlier byte. The same two-access sequence clears both bits.
- R11: When the clearing data access and a byte completion fall in the same cycle, the clear takes effect first. The new byte is stored, the flag stays set and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier (has side effects) |
| bus_addr | input | 2 | 0 control, 1 config/status, 2 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_mask | input | 1 | Interrupt mask from the host, 1 blocks `irq` |
| irq | output | 1 | Byte-complete interrupt request |
| sck | input | 1 | Serial clock from the controller |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Data-out drive enable |

## Verification
Two events can land in one cycle: the software data access that finishes the flag-clear sequence, and the completion of the next byte. The bench sets the flag, reads status, and then starts a second byte with phase 1. A concurrent thread issues the clearing data read at a sweep of offsets that moves across the completion edge. At every offset the final registers must show one of two legal outcomes: either the new byte is stored with the flag set, or the old byte is kept with flag and overrun clear. No offset may show any other combination. The outcome may change only once along the sweep, and both outcomes must appear.

// File: rtl/sspi_pkg.sv
package sspi_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic irq_en;
    logic master;
    logic enable;
  } ctrl_t;

  typedef struct packed {
    logic cpha;
    logic cpol;
  } cfg_t;

  // sampling edge is the rising one when idle level equals phase
  function automatic logic samples_on_rise(input cfg_t c);
    return c.cpol == c.cpha;
  endfunction
endpackage

// File: rtl/sspi_sync.sv
module sspi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= RST_VAL;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sspi_shifter.sv
module sspi_shifter import sspi_pkg::*; #(
  parameter int DW = 8,
  localparam int CW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  cfg_t          cfg,
  input  logic          sck_s,
  input  logic          ss_s,
  input  logic          mosi_s,
  input  logic          load_req,
  input  logic [DW-1:0] load_data,
  output logic          samp_evt,
  output logic          done_evt,
  output logic [DW-1:0] rx_byte,
  output logic [DW-1:0] shreg,
  output logic          miso
);
  logic          sck_d;
  logic [CW-1:0] cnt_q;
  logic          rise, fall, last_bit, load_ok;
  logic [DW-1:0] shreg_q;

  assign rise     = sck_s & ~sck_d;
  assign fall     = ~sck_s & sck_d;
  assign samp_evt = active & ~ss_s & (samples_on_rise(cfg) ? rise : fall);
  assign last_bit = cnt_q == CW'(DW-1);
  assign done_evt = samp_evt & last_bit;
  assign rx_byte  = {shreg_q[DW-2:0], mosi_s};
  // select high: any time; select low: only between bytes in phase 1
  assign load_ok  = ss_s | (cfg.cpha & (cnt_q == '0) & ~samp_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else begin
      sck_d <= sck_s;
      if (!active || ss_s)  cnt_q <= '0;
      else if (samp_evt)    cnt_q <= last_bit ? '0 : cnt_q + CW'(1);
      if (samp_evt)                 shreg_q <= rx_byte;
      else if (load_req && load_ok) shreg_q <= load_data;
    end
  end

  assign shreg = shreg_q;
  assign miso  = shreg_q[DW-1];

  AST_SS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |=> (cnt_q == '0)); // R5
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    samp_evt |=> (shreg_q[0] == $past(mosi_s))); // R3
endmodule

// File: rtl/sspi_regs.sv
module sspi_regs import sspi_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          irq_mask,
  input  logic          done_evt,
  input  logic [DW-1:0] rx_byte,
  output ctrl_t         ctrl,
  output cfg_t          cfg,
  output logic          load_req,
  output logic          wr_blocked,
  output logic          irq
);
  logic          flag_q, ovr_q, seen_q;
  logic [DW-1:0] rxbuf_q;
  logic          hit_ctrl, hit_cfg, hit_data;
  logic          stat_rd, data_acc, data_wr, clr, overrun_evt;

  function automatic logic [DW-1:0] status_word(input logic f, input logic o, input cfg_t c);
    logic [DW-1:0] w;
    w = '0;
    w[DW-1] = f;
    w[DW-2] = o;
    w[1:0]  = c;
    return w;
  endfunction

  assign hit_ctrl    = bus_addr == A_CTRL;
  assign hit_cfg     = bus_addr == A_CFG;
  assign hit_data    = bus_addr == A_DATA;
  assign stat_rd     = bus_sel & bus_rd & hit_cfg;
  assign data_acc    = bus_sel & (bus_rd | bus_wr) & hit_data;
  assign data_wr     = bus_sel & bus_wr & hit_data;
  assign clr         = data_acc & seen_q;
  assign wr_blocked  = data_wr & flag_q & ~seen_q;
  assign load_req    = data_wr & ~wr_blocked;
  assign overrun_evt = done_evt & flag_q & ~clr;
  assign irq         = flag_q & ctrl.irq_en & ~irq_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      cfg     <= '0;
      flag_q  <= 1'b0;
      ovr_q   <= 1'b0;
      seen_q  <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      if (bus_sel && bus_wr && hit_ctrl) ctrl <= ctrl_t'(bus_wdata[2:0]);
      if (bus_sel && bus_wr && hit_cfg)  cfg  <= cfg_t'(bus_wdata[1:0]);
      if (stat_rd && flag_q) seen_q <= 1'b1;
      if (clr) begin
        flag_q <= 1'b0;
        ovr_q  <= 1'b0;
        seen_q <= 1'b0;
      end
      if (overrun_evt) begin
        ovr_q <= 1'b1;
      end else if (done_evt) begin
        flag_q  <= 1'b1;
        rxbuf_q <= rx_byte;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[2:0] = ctrl;
      A_CFG:   bus_rdata = status_word(flag_q, ovr_q, cfg);
      A_DATA:  bus_rdata = rxbuf_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> flag_q); // R3
  AST_OVR_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |-> flag_q); // R10
  AST_OVR_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> (ovr_q && $stable(rxbuf_q))); // R10
  AST_CLEAR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !done_evt) |=> (!flag_q && !ovr_q)); // R8
  AST_RACE_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && done_evt) |=> (flag_q && !ovr_q)); // R11
endmodule

// File: rtl/sspi_target.sv
module sspi_target import sspi_pkg::*; #(
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          irq_mask,
  output logic          irq,
  input  logic          sck,
  input  logic          ss_n,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe
);
  logic          sck_s, ss_s, mosi_s;
  logic          active, samp_evt, done_evt, load_req, wr_blocked;
  logic [DW-1:0] rx_byte, shreg;
  ctrl_t         ctrl;
  cfg_t          cfg;

  sspi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, ss_n, mosi}), .q({sck_s, ss_s, mosi_s})
  );

  assign active  = ctrl.enable & ~ctrl.master;
  assign miso_oe = active & ~ss_s;

  sspi_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .active(active), .cfg(cfg),
    .sck_s(sck_s), .ss_s(ss_s), .mosi_s(mosi_s),
    .load_req(load_req), .load_data(bus_wdata),
    .samp_evt(samp_evt), .done_evt(done_evt), .rx_byte(rx_byte),
    .shreg(shreg), .miso(miso)
  );

  sspi_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_mask(irq_mask), .done_evt(done_evt), .rx_byte(rx_byte),
    .ctrl(ctrl), .cfg(cfg), .load_req(load_req), .wr_blocked(wr_blocked), .irq(irq)
  );

  AST_WR_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_blocked && !samp_evt) |=> $stable(shreg)); // R9
  AST_OFF_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !done_evt); // R2
endmodule

// File: tb/tb_sspi_target.sv
`timescale 1ns/1ps
module tb_sspi_target;
  localparam int H = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic irq_mask = 0, irq, sck = 0, ss_n = 1, mosi = 0, miso, miso_oe;
  logic t_cpol = 0, t_cpha = 0;
  int   runs = 0, fails = 0;

  always #10 clk = ~clk;

  sspi_target dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_mask(irq_mask), .irq(irq), .sck(sck), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] mo, output logic [7:0] mi);
    mi = '0;
    for (int b = 7; b >= 0; b--) begin
      if (!t_cpha) begin
        mosi = mo[b]; idle(H);
        mi[b] = miso; sck = ~t_cpol; idle(H); sck = t_cpol;
      end else begin
        sck = ~t_cpol; mosi = mo[b]; idle(H);
        mi[b] = miso; sck = t_cpol; idle(H);
      end
    end
    idle(H);
  endtask

  task automatic set_mode(input int m);
    t_cpol = m[0]; t_cpha = m[1];
    wr(2'd1, 8'(m));
    sck = t_cpol; idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, mi, tx, mo, st;
    int last_state;
    bit saw_early, saw_late;
    idle(3); rst_n = 1; idle(2);

    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 status", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 data", v, 0);
    chk(irq == 0 && miso == 0 && miso_oe == 0, "R1 pins", {irq, miso, miso_oe}, 0);

    // R3 R4 sweep over four modes
    wr(2'd0, 8'h01);
    for (int m = 0; m < 4; m++) begin
      set_mode(m);
      for (int p = 0; p < 12; p++) begin
        tx = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'((p * 73 + m * 29) & 255);
        mo = ~tx ^ 8'(p);
        wr(2'd2, tx);
        ss_n = 0; idle(H);
        xfer(mo, mi);
        ss_n = 1; idle(4);
        chk(mi == tx, "R4 miso byte", mi, tx);
        rd(2'd1, st); chk(st == (8'h80 | 8'(m)), "R3 flag set", st, 8'h80 | 8'(m));
        rd(2'd2, v);  chk(v == mo, "R3 received byte", v, mo);
        rd(2'd1, st); chk(st == 8'(m), "R8 flag cleared", st, m);
      end
    end

    // R2 master bit set: ignored
    wr(2'd0, 8'h03); set_mode(0);
    ss_n = 0; idle(H);
    chk(miso_oe == 0, "R2 oe off", miso_oe, 0);
    xfer(8'h5A, mi); ss_n = 1; idle(4);
    rd(2'd1, st); chk(st == 8'h00, "R2 no flag", st, 0);

    // R7 interrupt
    wr(2'd0, 8'h05);
    ss_n = 0; idle(H); xfer(8'h33, mi); ss_n = 1; idle(4);
    chk(irq == 1, "R7 irq on", irq, 1);
    irq_mask = 1; idle(1); chk(irq == 0, "R7 masked", irq, 0);
    irq_mask = 0; idle(1); chk(irq == 1, "R7 unmasked", irq, 1);
    rd(2'd1, st); rd(2'd2, v); idle(1);
    chk(irq == 0, "R7 irq off after clear", irq, 0);

    // R8 R9 inhibited write and no clear without status read
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h3C); ss_n = 0; idle(H); xfer(8'h96, mi); ss_n = 1; idle(4);
    wr(2'd2, 8'h11);
    rd(2'd1, st); chk(st == 8'h80, "R8 flag survives data access", st, 8'h80);
    rd(2'd2, v);  chk(v == 8'h96, "R8 data", v, 8'h96);
    rd(2'd1, st); chk(st == 8'h00, "R8 cleared", st, 0);
    ss_n = 0; idle(H); xfer(8'h00, mi); ss_n = 1; idle(4);
    chk(mi == 8'h96, "R9 write discarded", mi, 8'h96);
    rd(2'd1, st); rd(2'd2, v);

    // R5 phase 0 load blocked while select low
    wr(2'd2, 8'h3C); ss_n = 0; idle(H); xfer(8'h5A, mi);
    chk(mi == 8'h3C, "R5 first byte", mi, 8'h3C);
    rd(2'd1, st); wr(2'd2, 8'hE7);
    xfer(8'h0F, mi);
    chk(mi == 8'h5A, "R5 load blocked", mi, 8'h5A);
    ss_n = 1; idle(4);
    rd(2'd1, st); rd(2'd2, v); chk(v == 8'h0F, "R5 second rx", v, 8'h0F);
    wr(2'd2, 8'h77); ss_n = 0; idle(H); xfer(8'h01, mi); ss_n = 1; idle(4);
    chk(mi == 8'h77, "R5 load with select high", mi, 8'h77);
    rd(2'd1, st); rd(2'd2, v);

    // R6 phase 1 load between bytes with select low
    set_mode(2);
    ss_n = 0; idle(H);
    wr(2'd2, 8'hC3); xfer(8'h12, mi);
    chk(mi == 8'hC3, "R6 first load", mi, 8'hC3);
    rd(2'd1, st); wr(2'd2, 8'h4B); xfer(8'h21, mi);
    chk(mi == 8'h4B, "R6 load between bytes", mi, 8'h4B);
    rd(2'd1, st); rd(2'd2, v); chk(v == 8'h21, "R6 rx", v, 8'h21);

    // R10 overrun
    xfer(8'hAA, mi); xfer(8'h55, mi);
    rd(2'd1, st); chk(st == 8'hC2, "R10 overrun status", st, 8'hC2);
    rd(2'd2, v);  chk(v == 8'hAA, "R10 keeps first byte", v, 8'hAA);
    rd(2'd1, st); chk(st == 8'h02, "R10 overrun cleared", st, 8'h02);

    // R11 clear racing completion
    last_state = 0; saw_early = 0; saw_late = 0;
    for (int k = 78; k <= 104; k++) begin
      logic [7:0] dd, st2, dv;
      xfer(8'h3A, mi);
      rd(2'd1, st2);
      fork
        xfer(8'hB5, mi);
        begin idle(k); rd(2'd2, dd); end
      join
      rd(2'd1, st2); rd(2'd2, dv);
      if (st2 == 8'h82 && dv == 8'hB5) begin
        saw_early = 1;
        chk(last_state != 2, "R11 order", k, 0);
        last_state = 1;
      end else if (st2 == 8'h02 && dv == 8'h3A) begin
        saw_late = 1; last_state = 2;
        chk(1, "R11 late", 0, 0);
      end else begin
        chk(0, "R11 outcome", {st2, dv}, 16'h82B5);
      end
    end
    chk(saw_early && saw_late, "R11 both outcomes", {saw_early, saw_late}, 3);
    ss_n = 1; idle(4);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule